// File: doc/BRIEF.md
# Fetch Window Tracking Queue

This block keeps one record per tracked piece of a fetched 64-byte code line, from the moment the fetch unit hands the line over until the code it holds retires. Each record carries the line address, a branch summary, the part number within its line and a flag marking the line's final part. A line with no branches fits in a single record. When one predictor entry cannot carry prediction to the end of the line, the line takes several consecutive records, and all of them are written in the same cycle or none is. Retirement frees records from the oldest end. A flush names the youngest record that survives and discards everything younger in one cycle.

In single-thread mode the queue offers 64 records, all to thread 0. In two-thread mode each thread owns a private half of 32 records with its own pointers. A selector input picks which thread's oldest record, free count and full flag appear on the outputs.

Top module: `fwt_tracker`

## Requirements
- R1: After reset the queue is empty in single-thread mode: `free_cnt` is 64, `full` is low and `head_valid` is low.
- R2: An accepted allocation writes 1+`alloc_extra` consecutive records starting at the current tail. `alloc_idx` gives the first index. Record k holds the line address, the branch summary, part number k and a last flag that is set only on part `alloc_extra`.
- R3: If the free count of the requesting thread is below 1+`alloc_extra`, `alloc_ok` is low in that cycle, no record is written and no pointer moves.
- R4: Retiring n records advances the oldest index by n and raises the free count by n. The head outputs then show the new oldest record.
- R5: `flush_valid` with `flush_all` low keeps the records from the oldest up to `flush_idx` and discards the younger ones, so the next allocation lands at `flush_idx`+1. With `flush_all` high the thread is emptied. In a flush cycle the flushed thread's allocation and retirement requests are ignored.
- R6: Indices wrap within the thread's region (modulo 64 in single-thread mode).
- R7: In single-thread mode only thread 0 (`alloc_tid`=0) may allocate. A request with `alloc_tid`=1 gets `alloc_ok` low.
- R8: In two-thread mode thread 0 uses indices 0..31 and thread 1 uses 32..63. Each thread has a capacity of 32, and one thread's activity leaves the other's state unchanged.
- R9: A new value on `smt_mode` takes effect only on a clock edge where both threads are empty. While it differs from the active mode, every allocation is refused. On the switch, both threads restart at their region base.
- R10: `free_cnt` equals region capacity minus occupied records for the selected thread. `full` is high exactly when `free_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smt_mode | input | 1 | Requested mode: 1 = two threads, 0 = single thread |
| alloc_valid | input | 1 | Allocation request |
| alloc_tid | input | 1 | Requesting thread |
| alloc_line | input | 26 | Line address (64-byte granule) |
| alloc_extra | input | 2 | Extra records needed beyond the first |
| alloc_br | input | 8 | Branch summary stored in every record of the line |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_idx | output | 6 | Index of the first record of the line |
| ret_valid | input | 1 | Retirement request |
| ret_tid | input | 1 | Retiring thread |
| ret_cnt | input | 3 | Number of oldest records to free |
| flush_valid | input | 1 | Flush request |
| flush_tid | input | 1 | Flushed thread |
| flush_all | input | 1 | Discard every record of the thread |
| flush_idx | input | 6 | Youngest surviving index |
| peek_tid | input | 1 | Thread shown on the status and head outputs |
| free_cnt | output | 7 | Free records of the selected thread |
| full | output | 1 | Selected thread has no free record |
| head_valid | output | 1 | Selected thread holds at least one record |
| head_idx | output | 6 | Index of the oldest record |
| head_line | output | 26 | Line address of the oldest record |
| head_br | output | 8 | Branch summary of the oldest record |
| head_part | output | 2 | Part number of the oldest record |
| head_last | output | 1 | Oldest record is its line's final part |

## Verification
`alloc_ok` and `alloc_idx` are combinational on the request and the current state. The bench samples them one nanosecond after it drives the request, well before the next rising edge. Pointer updates, record writes and the mode switch all land on the edge that takes the request, so free count, full and the head outputs are sampled one nanosecond after that edge. The one exception is a mode change: it waits for an edge on which both threads are already empty, so the bench inserts an idle cycle after the last retirement and checks the new capacity only after that edge.

// File: rtl/fwt_pkg.sv
package fwt_pkg;
    localparam int unsigned FWT_DEPTH = 64;
    localparam int unsigned LINE_W    = 26;
    localparam int unsigned BR_W      = 8;
    localparam int unsigned EXTRA_W   = 2;
    localparam int unsigned RET_W     = 3;
    localparam int unsigned NUM_THR   = 2;

    localparam int unsigned IDX_W     = $clog2(FWT_DEPTH);
    localparam int unsigned CNT_W     = IDX_W + 1;
    localparam int unsigned MAX_PARTS = 1 << EXTRA_W;
    localparam int unsigned HALF      = FWT_DEPTH / 2;

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [EXTRA_W-1:0] part_t;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [BR_W-1:0]   br;
        part_t             part;
        logic              last;
    } fw_entry_t;

    function automatic cnt_t region_size(input logic smt);
        return smt ? cnt_t'(HALF) : cnt_t'(FWT_DEPTH);
    endfunction

    function automatic idx_t region_mask(input logic smt);
        return smt ? idx_t'(HALF - 1) : idx_t'(FWT_DEPTH - 1);
    endfunction

    function automatic idx_t region_base(input logic smt, input logic tid);
        return (smt && tid) ? idx_t'(HALF) : idx_t'(0);
    endfunction

    function automatic idx_t wrap_idx(input logic smt, input logic tid, input idx_t off);
        return region_base(smt, tid) | (off & region_mask(smt));
    endfunction
endpackage

// File: rtl/fwt_thread_ctrl.sv
module fwt_thread_ctrl
    import fwt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_smt,
    input  logic mode_reset,
    input  logic alloc_go,
    input  cnt_t alloc_need,
    input  logic ret_go,
    input  cnt_t ret_n,
    input  logic flush_go,
    input  logic flush_clear,
    input  idx_t flush_idx,
    output idx_t head_off,
    output idx_t tail_off,
    output cnt_t cnt,
    output cnt_t free
);
    idx_t mask;
    cnt_t size;
    idx_t keep_dist;

    always_comb begin
        mask      = region_mask(mode_smt);
        size      = region_size(mode_smt);
        tail_off  = (head_off + cnt[IDX_W-1:0]) & mask;
        free      = size - cnt;
        keep_dist = ((flush_idx & mask) - head_off) & mask;
    end

    always_ff @(posedge clk) begin
        if (rst || mode_reset) begin
            head_off <= '0;
            cnt      <= '0;
        end else if (flush_go) begin
            cnt <= flush_clear ? cnt_t'(0) : cnt_t'({1'b0, keep_dist}) + cnt_t'(1);
        end else begin
            if (ret_go)
                head_off <= (head_off + ret_n[IDX_W-1:0]) & mask;
            cnt <= cnt + (alloc_go ? alloc_need : cnt_t'(0)) - (ret_go ? ret_n : cnt_t'(0));
        end
    end

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= size);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_go |-> alloc_need <= free);
    // R4
    ret_within_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_go && !flush_go) |-> ret_n <= cnt);
    // R2
    alloc_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_go && !ret_go && !flush_go && !mode_reset) |=> cnt == $past(cnt) + $past(alloc_need));
    // R5
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_go && flush_clear && !mode_reset) |=> cnt == '0);
endmodule

// File: rtl/fwt_entry_store.sv
module fwt_entry_store
    import fwt_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_smt,
    input  logic              wr_tid,
    input  idx_t              wr_tail,
    input  part_t             wr_extra,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [BR_W-1:0]   wr_br,
    input  idx_t              rd_idx,
    output fw_entry_t         rd_entry
);
    fw_entry_t mem [FWT_DEPTH];

    always_ff @(posedge clk) begin
        for (int k = 0; k < MAX_PARTS; k++) begin
            if (wr_en && (part_t'(k) <= wr_extra)) begin
                mem[wrap_idx(wr_smt, wr_tid, wr_tail + idx_t'(k))] <=
                    {wr_line, wr_br, part_t'(k), (part_t'(k) == wr_extra)};
            end
        end
    end

    assign rd_entry = mem[rd_idx];
endmodule

// File: rtl/fwt_tracker.sv
module fwt_tracker
    import fwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smt_mode,
    input  logic              alloc_valid,
    input  logic              alloc_tid,
    input  logic [LINE_W-1:0] alloc_line,
    input  logic [EXTRA_W-1:0] alloc_extra,
    input  logic [BR_W-1:0]   alloc_br,
    output logic              alloc_ok,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              ret_valid,
    input  logic              ret_tid,
    input  logic [RET_W-1:0]  ret_cnt,
    input  logic              flush_valid,
    input  logic              flush_tid,
    input  logic              flush_all,
    input  logic [IDX_W-1:0]  flush_idx,
    input  logic              peek_tid,
    output logic [CNT_W-1:0]  free_cnt,
    output logic              full,
    output logic              head_valid,
    output logic [IDX_W-1:0]  head_idx,
    output logic [LINE_W-1:0] head_line,
    output logic [BR_W-1:0]   head_br,
    output logic [EXTRA_W-1:0] head_part,
    output logic              head_last
);
    logic      mode_q;
    logic      mode_switch;
    cnt_t      need;
    idx_t      thr_head [NUM_THR];
    idx_t      thr_tail [NUM_THR];
    cnt_t      thr_cnt  [NUM_THR];
    cnt_t      thr_free [NUM_THR];
    logic      thr_alloc [NUM_THR];
    logic      thr_ret   [NUM_THR];
    logic      thr_flush [NUM_THR];
    fw_entry_t head_ent;

    always_comb begin
        need        = cnt_t'(alloc_extra) + cnt_t'(1);
        mode_switch = (smt_mode != mode_q) && (thr_cnt[0] == '0) && (thr_cnt[1] == '0);
        alloc_ok    = alloc_valid
                   && (smt_mode == mode_q)
                   && (!alloc_tid || mode_q)
                   && !(flush_valid && (flush_tid == alloc_tid))
                   && (need <= thr_free[alloc_tid]);
        alloc_idx   = wrap_idx(mode_q, alloc_tid, thr_tail[alloc_tid]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= 1'b0;
        else if (mode_switch)
            mode_q <= smt_mode;
    end

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        always_comb begin
            thr_flush[t] = flush_valid && (flush_tid == 1'(t));
            thr_alloc[t] = alloc_ok && (alloc_tid == 1'(t));
            thr_ret[t]   = ret_valid && (ret_tid == 1'(t)) && !thr_flush[t];
        end

        fwt_thread_ctrl u_ctrl (
            .clk        (clk),
            .rst        (rst),
            .mode_smt   (mode_q),
            .mode_reset (mode_switch),
            .alloc_go   (thr_alloc[t]),
            .alloc_need (need),
            .ret_go     (thr_ret[t]),
            .ret_n      (cnt_t'(ret_cnt)),
            .flush_go   (thr_flush[t]),
            .flush_clear(flush_all),
            .flush_idx  (flush_idx),
            .head_off   (thr_head[t]),
            .tail_off   (thr_tail[t]),
            .cnt        (thr_cnt[t]),
            .free       (thr_free[t])
        );
    end

    fwt_entry_store u_store (
        .clk     (clk),
        .wr_en   (alloc_ok),
        .wr_smt  (mode_q),
        .wr_tid  (alloc_tid),
        .wr_tail (thr_tail[alloc_tid]),
        .wr_extra(alloc_extra),
        .wr_line (alloc_line),
        .wr_br   (alloc_br),
        .rd_idx  (head_idx),
        .rd_entry(head_ent)
    );

    always_comb begin
        head_idx   = wrap_idx(mode_q, peek_tid, thr_head[peek_tid]);
        head_valid = thr_cnt[peek_tid] != '0;
        free_cnt   = thr_free[peek_tid];
        full       = thr_free[peek_tid] == '0;
        head_line  = head_ent.line;
        head_br    = head_ent.br;
        head_part  = head_ent.part;
        head_last  = head_ent.last;
    end

    // R9
    mode_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> ($past(thr_cnt[0]) == '0 && $past(thr_cnt[1]) == '0));
    // R7
    single_t1_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_q |-> thr_cnt[1] == '0);
    // R8
    smt_region_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_ok && mode_q) |-> alloc_idx[IDX_W-1] == alloc_tid);
endmodule

// File: tb/fwt_tracker_tb.sv
module fwt_tracker_tb;
    import fwt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smt_mode = 1'b0;
    logic alloc_valid = 1'b0, alloc_tid = 1'b0;
    logic [LINE_W-1:0] alloc_line = '0;
    logic [EXTRA_W-1:0] alloc_extra = '0;
    logic [BR_W-1:0] alloc_br = '0;
    logic alloc_ok;
    logic [IDX_W-1:0] alloc_idx;
    logic ret_valid = 1'b0, ret_tid = 1'b0;
    logic [RET_W-1:0] ret_cnt = '0;
    logic flush_valid = 1'b0, flush_tid = 1'b0, flush_all = 1'b0;
    logic [IDX_W-1:0] flush_idx = '0;
    logic peek_tid = 1'b0;
    logic [CNT_W-1:0] free_cnt;
    logic full, head_valid, head_last;
    logic [IDX_W-1:0] head_idx;
    logic [LINE_W-1:0] head_line;
    logic [BR_W-1:0] head_br;
    logic [EXTRA_W-1:0] head_part;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fwt_tracker u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge_clear();
        @(posedge clk);
        #1;
        alloc_valid = 1'b0; ret_valid = 1'b0; flush_valid = 1'b0; flush_all = 1'b0;
    endtask

    // op 0 alloc, 1 retire, 2 flush; arg = extra / retire count / surviving index
    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  arg;
        logic [15:0] line;
        logic        e_ok;
        logic [5:0]  e_idx;
        logic [6:0]  e_free;
        logic        e_hv;
        logic [5:0]  e_hidx;
        logic [15:0] e_hline;
        logic [1:0]  e_hpart;
        logic        e_hlast;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 6'd0, 16'hA001, 1'b1, 6'd0, 7'd63, 1'b1, 6'd0, 16'hA001, 2'd0, 1'b1},
        '{2'd0, 6'd3, 16'hA002, 1'b1, 6'd1, 7'd59, 1'b1, 6'd0, 16'hA001, 2'd0, 1'b1},
        '{2'd0, 6'd1, 16'hA003, 1'b1, 6'd5, 7'd57, 1'b1, 6'd0, 16'hA001, 2'd0, 1'b1},
        '{2'd1, 6'd1, 16'h0000, 1'b0, 6'd0, 7'd58, 1'b1, 6'd1, 16'hA002, 2'd0, 1'b0},
        '{2'd1, 6'd2, 16'h0000, 1'b0, 6'd0, 7'd60, 1'b1, 6'd3, 16'hA002, 2'd2, 1'b0},
        '{2'd2, 6'd4, 16'h0000, 1'b0, 6'd0, 7'd62, 1'b1, 6'd3, 16'hA002, 2'd2, 1'b0},
        '{2'd0, 6'd0, 16'hA004, 1'b1, 6'd5, 7'd61, 1'b1, 6'd3, 16'hA002, 2'd2, 1'b0},
        '{2'd1, 6'd3, 16'h0000, 1'b0, 6'd0, 7'd64, 1'b0, 6'd6, 16'h0000, 2'd0, 1'b0}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int first_idx;
        int last_idx;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check("R1 free", int'(free_cnt), 64);
        check("R1 full", int'(full), 0);
        check("R1 head_valid", int'(head_valid), 0);

        // Table walk: R2 R4 R5 in single-thread mode
        foreach (VECS[i]) begin
            case (VECS[i].op)
                2'd0: begin
                    alloc_valid = 1'b1; alloc_tid = 1'b0;
                    alloc_line = LINE_W'(VECS[i].line);
                    alloc_extra = VECS[i].arg[1:0];
                    alloc_br = 8'h5A;
                end
                2'd1: begin
                    ret_valid = 1'b1; ret_tid = 1'b0; ret_cnt = VECS[i].arg[2:0];
                end
                default: begin
                    flush_valid = 1'b1; flush_tid = 1'b0; flush_idx = VECS[i].arg;
                end
            endcase
            #1;
            check("R2 alloc_ok", int'(alloc_ok), int'(VECS[i].e_ok));
            if (VECS[i].e_ok) check("R2 alloc_idx", int'(alloc_idx), int'(VECS[i].e_idx));
            edge_clear();
            check("R4 R5 free", int'(free_cnt), int'(VECS[i].e_free));
            check("R4 head_valid", int'(head_valid), int'(VECS[i].e_hv));
            check("R4 head_idx", int'(head_idx), int'(VECS[i].e_hidx));
            if (VECS[i].e_hv) begin
                check("R2 head_line", int'(head_line), int'(VECS[i].e_hline));
                check("R2 head_part", int'(head_part), int'(VECS[i].e_hpart));
                check("R2 head_last", int'(head_last), int'(VECS[i].e_hlast));
                check("R2 head_br", int'(head_br), 8'h5A);
            end
        end

        // R6 fill from index 6 with 16 four-record lines, wrapping to index 2
        first_idx = -1; last_idx = -1;
        for (int k = 0; k < 16; k++) begin
            alloc_valid = 1'b1; alloc_tid = 1'b0; alloc_extra = 2'd3;
            alloc_line = LINE_W'(16'hB000 + k); alloc_br = 8'h11;
            #1;
            check("R6 alloc_ok fill", int'(alloc_ok), 1);
            if (k == 0) first_idx = int'(alloc_idx);
            if (k == 15) last_idx = int'(alloc_idx);
            edge_clear();
        end
        check("R6 first idx", first_idx, 6);
        check("R6 wrapped idx", last_idx, 2);
        check("R10 free at full", int'(free_cnt), 0);
        check("R10 full", int'(full), 1);

        // R3 stall when no room
        alloc_valid = 1'b1; alloc_extra = 2'd0; alloc_line = LINE_W'(16'hDEAD);
        #1 check("R3 alloc refused when full", int'(alloc_ok), 0);
        edge_clear();
        check("R3 free unchanged", int'(free_cnt), 0);
        ret_valid = 1'b1; ret_tid = 1'b0; ret_cnt = 3'd1;
        edge_clear();
        check("R4 free after retire", int'(free_cnt), 1);
        check("R4 head idx", int'(head_idx), 7);
        alloc_valid = 1'b1; alloc_extra = 2'd1; alloc_line = LINE_W'(16'hDEAD);
        #1 check("R3 two-record line refused", int'(alloc_ok), 0);
        edge_clear();
        check("R3 free still 1", int'(free_cnt), 1);
        check("R3 head line untouched", int'(head_line), 16'hB000);
        check("R3 head part untouched", int'(head_part), 1);

        // R5 flush_all
        flush_valid = 1'b1; flush_tid = 1'b0; flush_all = 1'b1;
        edge_clear();
        check("R5 flush_all free", int'(free_cnt), 64);
        check("R5 flush_all empty", int'(head_valid), 0);

        // R7 thread 1 refused in single mode
        alloc_valid = 1'b1; alloc_tid = 1'b1; alloc_extra = 2'd0;
        #1 check("R7 t1 refused", int'(alloc_ok), 0);
        edge_clear();
        check("R7 t0 free unchanged", int'(free_cnt), 64);

        // R9 mode change waits for empty
        alloc_valid = 1'b1; alloc_tid = 1'b0; alloc_extra = 2'd0; alloc_line = LINE_W'(16'hC0DE);
        #1 check("R9 alloc idx", int'(alloc_idx), 7);
        edge_clear();
        smt_mode = 1'b1;
        alloc_valid = 1'b1; alloc_tid = 1'b0;
        #1 check("R9 alloc refused during mode change", int'(alloc_ok), 0);
        edge_clear();
        check("R9 mode held while busy", int'(free_cnt), 63);
        ret_valid = 1'b1; ret_tid = 1'b0; ret_cnt = 3'd1;
        edge_clear();
        edge_clear();
        check("R9 SMT capacity", int'(free_cnt), 32);

        // R8 two-thread regions
        alloc_valid = 1'b1; alloc_tid = 1'b1; alloc_extra = 2'd1;
        alloc_line = LINE_W'(16'hC001); alloc_br = 8'h22;
        #1 check("R8 t1 ok", int'(alloc_ok), 1);
        check("R8 t1 base idx", int'(alloc_idx), 32);
        edge_clear();
        alloc_valid = 1'b1; alloc_tid = 1'b0; alloc_extra = 2'd0; alloc_line = LINE_W'(16'hC002);
        #1 check("R8 t0 base idx", int'(alloc_idx), 0);
        edge_clear();
        check("R8 t0 free", int'(free_cnt), 31);
        peek_tid = 1'b1;
        #1;
        check("R8 t1 free", int'(free_cnt), 30);
        check("R8 t1 head idx", int'(head_idx), 32);
        check("R8 t1 head line", int'(head_line), 16'hC001);
        check("R8 t1 head last", int'(head_last), 0);
        for (int k = 0; k < 7; k++) begin
            alloc_valid = 1'b1; alloc_tid = 1'b0; alloc_extra = 2'd3;
            edge_clear();
        end
        alloc_valid = 1'b1; alloc_tid = 1'b0; alloc_extra = 2'd3;
        #1 check("R8 R3 t0 region full", int'(alloc_ok), 0);
        edge_clear();
        check("R8 t1 unaffected", int'(free_cnt), 30);

        // R5 flush ignores same-cycle alloc and retire of that thread
        flush_valid = 1'b1; flush_tid = 1'b1; flush_idx = 6'd32;
        alloc_valid = 1'b1; alloc_tid = 1'b1; alloc_extra = 2'd0;
        ret_valid = 1'b1; ret_tid = 1'b1; ret_cnt = 3'd1;
        #1 check("R5 alloc ignored on flush", int'(alloc_ok), 0);
        edge_clear();
        check("R5 t1 free after flush", int'(free_cnt), 31);
        check("R5 retire ignored", int'(head_idx), 32);
        alloc_valid = 1'b1; alloc_tid = 1'b1; alloc_extra = 2'd0; alloc_line = LINE_W'(16'hC003);
        #1 check("R5 next alloc after survivor", int'(alloc_idx), 33);
        edge_clear();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule